// File: doc/BRIEF.md
# Receive Pair Polarity Corrector

This block decides whether a twisted-pair receive pair has been wired with its two conductors swapped, and inverts the recovered serial data when it has. It is fed by an analog front end and a frame decoder that are outside the block. The front end reports each link integrity pulse together with the polarity at which it was seen. The decoder reports the polarity of the end-of-frame delimiter of each valid frame. A link monitor supplies the pass/fail state of the link.

While the link is failed, pulses of either polarity are passed on to the link monitor, and the block keeps a short history of their polarities. When the link moves to pass, the block chooses an initial polarity only if the most recent pulses all agree. From then on, only pulses of the chosen polarity are marked as acceptable. The first valid delimiter seen while the link passes hands control to the delimiter, and each later delimiter sets the polarity directly. A link failure returns the block to pulse-based detection. A change to the applied inversion waits until no frame is in progress.

Polarity encoding used throughout: a polarity bit of 1 means the event was seen reversed, so the data must be inverted. A bit of 0 means normal.

Top module: `rxpol_corr`

## Requirements
- R1: After reset, `invert` is 0 and `etd_mode` is 0, so `rx_dout` equals `rx_din`.
- R2: While `link_ok` is 0, `lp_accept` follows `lp_evt` whatever the value of `lp_neg`.
- R3: When `link_ok` rises and the last HIST_LEN pulses received during link fail (default 5) all carry the same `lp_neg` value, that value becomes the polarity target. With no frame active, `invert` takes it on the second rising edge after `link_ok` rises. This works in both directions.
- R4: When `link_ok` rises after fewer than HIST_LEN pulses, or after pulses of mixed polarity among the last HIST_LEN, the polarity target and `invert` keep their previous values.
- R5: While `link_ok` is 1, `lp_accept` is 1 only for a pulse whose `lp_neg` equals the current polarity target.
- R6: An `etd_evt` while `link_ok` is 1 sets `etd_mode` one cycle later and makes `etd_neg` the polarity target. Pulse acceptance then follows that polarity.
- R7: An `etd_evt` while `link_ok` is 0 has no effect on `etd_mode` or on the polarity target.
- R8: While `link_ok` is 0, `etd_mode` is cleared. Pulses counted before the most recent pass period are discarded, so a new decision needs HIST_LEN fresh pulses.
- R9: While `frame_active` is 1, `invert` holds its value. A pending change is applied one cycle after `frame_active` returns to 0.
- R10: `rx_dout` equals `rx_din` XOR `invert` on every lane, with no register in the path.
- R11: Only the most recent HIST_LEN pulses count. Older pulses of the other polarity do not block a decision.
- R12: The polarity is not reset by a link failure. `invert` keeps its value through link fail until a new decision is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_ok | input | 1 | Link state from the link monitor, 1 = pass |
| lp_evt | input | 1 | One-cycle strobe, a link pulse was detected |
| lp_neg | input | 1 | Polarity of that pulse, 1 = reversed |
| etd_evt | input | 1 | One-cycle strobe, a valid frame ended |
| etd_neg | input | 1 | Polarity of that frame's delimiter, 1 = reversed |
| frame_active | input | 1 | A frame is being received |
| rx_din | input | RX_W | Received serial data before correction |
| invert | output | 1 | Applied inversion |
| lp_accept | output | 1 | Pulse qualifies for the link monitor's count |
| etd_mode | output | 1 | Polarity is governed by delimiters |
| rx_dout | output | RX_W | Corrected data toward the decoder |

## Verification
The pulse trains before link pass are chosen to separate three cases. A uniform run of five in each direction must produce a decision. A mixed run and a run too short to decide must leave the polarity alone. A run whose older pulses disagree but whose last five agree shows that the window slides. A short train split by a pass period shows that the history is re-armed. Delimiter events are given both while the link passes and while it fails, which shows that they are qualified by link state. Holding a frame active across a delimiter-driven change separates deferred application from immediate application. Pulses of both polarities are offered in each state, which checks the acceptance filter against the chosen polarity.

// File: rtl/rxpol_pkg.sv
package rxpol_pkg;
  typedef enum logic {
    POL_NORMAL   = 1'b0,
    POL_REVERSED = 1'b1
  } pol_e;
endpackage

// File: rtl/rxpol_hist.sv
module rxpol_hist #(
  parameter int HIST_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic pol_in,
  output logic full,
  output logic uniform,
  output logic pol_last
);
  localparam int CNT_W = $clog2(HIST_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(HIST_LEN);

  logic [HIST_LEN-1:0] hist_q, hist_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;

  always_comb begin
    hist_d = hist_q;
    cnt_d  = cnt_q;
    if (clr) begin
      hist_d = '0;
      cnt_d  = '0;
    end else if (push) begin
      hist_d = {hist_q[HIST_LEN-2:0], pol_in};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      cnt_q  <= '0;
    end else begin
      hist_q <= hist_d;
      cnt_q  <= cnt_d;
    end
  end

  assign full     = (cnt_q == CNT_MAX);
  assign uniform  = (&hist_q) | (~|hist_q);
  assign pol_last = hist_q[0];
endmodule

// File: rtl/rxpol_ctrl.sv
module rxpol_ctrl
  import rxpol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic link_ok,
  input  logic hist_full,
  input  logic hist_uniform,
  input  logic hist_pol,
  input  logic etd_evt,
  input  logic etd_neg,
  output logic pol_tgt,
  output logic etd_mode
);
  logic link_q, link_d;
  logic etd_q, etd_d;
  pol_e pol_q, pol_d;
  logic pass_entry;

  assign pass_entry = link_ok & ~link_q;

  always_comb begin
    link_d = link_ok;
    etd_d  = etd_q;
    pol_d  = pol_q;
    if (!link_ok) begin
      etd_d = 1'b0;
    end else if (etd_evt) begin
      etd_d = 1'b1;
      pol_d = pol_e'(etd_neg);
    end else if (pass_entry && !etd_q && hist_full && hist_uniform) begin
      pol_d = pol_e'(hist_pol);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      etd_q  <= 1'b0;
      pol_q  <= POL_NORMAL;
    end else begin
      link_q <= link_d;
      etd_q  <= etd_d;
      pol_q  <= pol_d;
    end
  end

  assign pol_tgt  = pol_q;
  assign etd_mode = etd_q;
endmodule

// File: rtl/rxpol_apply.sv
module rxpol_apply #(
  parameter int RX_W = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pol_tgt,
  input  logic            frame_active,
  input  logic [RX_W-1:0] din,
  output logic            invert,
  output logic [RX_W-1:0] dout
);
  logic inv_q, inv_d;
  logic upd_en;

  assign upd_en = ~frame_active;

  always_comb begin
    inv_d = inv_q;
    if (upd_en) inv_d = pol_tgt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inv_q <= 1'b0;
    else        inv_q <= inv_d;
  end

  for (genvar g = 0; g < RX_W; g++) begin : g_lane
    assign dout[g] = din[g] ^ inv_q;
  end

  assign invert = inv_q;
endmodule

// File: rtl/rxpol_corr.sv
module rxpol_corr #(
  parameter int RX_W     = 1,
  parameter int HIST_LEN = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            link_ok,
  input  logic            lp_evt,
  input  logic            lp_neg,
  input  logic            etd_evt,
  input  logic            etd_neg,
  input  logic            frame_active,
  input  logic [RX_W-1:0] rx_din,
  output logic            invert,
  output logic            lp_accept,
  output logic            etd_mode,
  output logic [RX_W-1:0] rx_dout
);
  logic hist_full, hist_uniform, hist_pol;
  logic pol_tgt;
  logic hist_push;

  assign hist_push = lp_evt & ~link_ok;

  rxpol_hist #(.HIST_LEN(HIST_LEN)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (link_ok),
    .push    (hist_push),
    .pol_in  (lp_neg),
    .full    (hist_full),
    .uniform (hist_uniform),
    .pol_last(hist_pol)
  );

  rxpol_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .link_ok     (link_ok),
    .hist_full   (hist_full),
    .hist_uniform(hist_uniform),
    .hist_pol    (hist_pol),
    .etd_evt     (etd_evt),
    .etd_neg     (etd_neg),
    .pol_tgt     (pol_tgt),
    .etd_mode    (etd_mode)
  );

  rxpol_apply #(.RX_W(RX_W)) u_apply (
    .clk         (clk),
    .rst_n       (rst_n),
    .pol_tgt     (pol_tgt),
    .frame_active(frame_active),
    .din         (rx_din),
    .invert      (invert),
    .dout        (rx_dout)
  );

  assign lp_accept = lp_evt & (~link_ok | (lp_neg == pol_tgt));
endmodule

// File: rtl/rxpol_corr_chk.sv
module rxpol_corr_chk (
  input logic clk,
  input logic rst_n,
  input logic link_ok,
  input logic lp_evt,
  input logic lp_neg,
  input logic lp_accept,
  input logic etd_evt,
  input logic etd_mode,
  input logic frame_active,
  input logic invert,
  input logic pol_tgt
);
  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!invert && !etd_mode));

  p_fail_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_ok && lp_evt) |-> lp_accept);

  p_pass_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok && lp_accept) |-> (lp_neg == pol_tgt));

  p_etd_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ok && etd_evt) |=> etd_mode);

  p_fail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !link_ok |=> !etd_mode);

  p_defer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_active |=> $stable(invert));
endmodule

bind rxpol_corr rxpol_corr_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .link_ok     (link_ok),
  .lp_evt      (lp_evt),
  .lp_neg      (lp_neg),
  .lp_accept   (lp_accept),
  .etd_evt     (etd_evt),
  .etd_mode    (etd_mode),
  .frame_active(frame_active),
  .invert      (invert),
  .pol_tgt     (pol_tgt)
);

// File: tb/rxpol_corr_tb.sv
module rxpol_corr_tb;
  localparam int W = 4;

  logic clk, rst_n, link_ok, lp_evt, lp_neg, etd_evt, etd_neg, frame_active;
  logic [W-1:0] rx_din, rx_dout;
  logic invert, lp_accept, etd_mode;

  rxpol_corr #(.RX_W(W), .HIST_LEN(5)) u_dut (
    .clk(clk), .rst_n(rst_n), .link_ok(link_ok), .lp_evt(lp_evt), .lp_neg(lp_neg),
    .etd_evt(etd_evt), .etd_neg(etd_neg), .frame_active(frame_active),
    .rx_din(rx_din), .invert(invert), .lp_accept(lp_accept),
    .etd_mode(etd_mode), .rx_dout(rx_dout)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  typedef enum int {K_INV, K_ETD, K_ACC, K_DOUT} kind_e;
  typedef struct {
    string       req;
    kind_e       kind;
    logic [W-1:0] val;
  } item_t;

  item_t sb_q[$];
  event  chk_ev;
  int    n_run = 0, n_fail = 0;
  bit    done = 0;

  // monitor: pops expected items and compares with live outputs
  initial begin
    forever begin
      @(chk_ev);
      while (sb_q.size() > 0) begin
        item_t it;
        logic [W-1:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          K_INV:   got = {{(W-1){1'b0}}, invert};
          K_ETD:   got = {{(W-1){1'b0}}, etd_mode};
          K_ACC:   got = {{(W-1){1'b0}}, lp_accept};
          default: got = rx_dout;
        endcase
        n_run++;
        if (got !== it.val) begin
          n_fail++;
          $display("FAIL %s kind=%0d got=%h exp=%h", it.req, it.kind, got, it.val);
        end
      end
    end
  end

  task automatic expect_v(input kind_e k, input logic [W-1:0] v, input string req);
    item_t it;
    it.req = req; it.kind = k; it.val = v;
    sb_q.push_back(it);
    #1;
    -> chk_ev;
    wait (sb_q.size() == 0);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic neg);
    lp_evt = 1'b1; lp_neg = neg;
    step(1);
    lp_evt = 1'b0;
  endtask

  task automatic delim(input logic neg);
    etd_evt = 1'b1; etd_neg = neg;
    step(1);
    etd_evt = 1'b0;
  endtask

  task automatic go_link(input logic v);
    link_ok = v;
    step(2);
  endtask

  task automatic probe_accept(input logic neg, input logic exp, input string req);
    lp_evt = 1'b1; lp_neg = neg;
    expect_v(K_ACC, {{(W-1){1'b0}}, exp}, req);
    @(negedge clk);
    lp_evt = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; link_ok = 0; lp_evt = 0; lp_neg = 0; etd_evt = 0; etd_neg = 0;
    frame_active = 0; rx_din = 4'b1010;
    step(3);
    // R1 reset state
    expect_v(K_INV, 0, "R1");
    expect_v(K_ETD, 0, "R1");
    expect_v(K_DOUT, 4'b1010, "R1");
    rst_n = 1;
    step(2);
    // R2 link fail accepts both polarities
    probe_accept(1'b1, 1'b1, "R2");
    probe_accept(1'b0, 1'b1, "R2");
    // R11 older normal pulses, last five reversed; R3 decision
    go_link(1'b1); go_link(1'b0);
    repeat (3) pulse(1'b0);
    repeat (5) pulse(1'b1);
    link_ok = 1'b1;
    step(1);
    expect_v(K_INV, 0, "R3 latency");
    step(1);
    expect_v(K_INV, 1, "R3 R11");
    // R10 data inverted on every lane
    expect_v(K_DOUT, 4'b0101, "R10");
    // R5 pass filter
    probe_accept(1'b0, 1'b0, "R5");
    probe_accept(1'b1, 1'b1, "R5");
    // R6 / R9 delimiter during frame
    frame_active = 1'b1;
    delim(1'b0);
    expect_v(K_ETD, 1, "R6");
    step(4);
    expect_v(K_INV, 1, "R9 held");
    frame_active = 1'b0;
    step(1);
    expect_v(K_INV, 0, "R9 applied");
    probe_accept(1'b0, 1'b1, "R6 filter");
    // R8 fail clears delimiter mode; R12 invert kept
    link_ok = 1'b0;
    step(1);
    expect_v(K_ETD, 0, "R8");
    // R7 delimiter in fail ignored
    delim(1'b1);
    expect_v(K_ETD, 0, "R7");
    go_link(1'b1);
    expect_v(K_INV, 0, "R7 R4");
    // R8 re-arm: 3 + 2 pulses split by a pass period
    go_link(1'b0);
    repeat (3) pulse(1'b1);
    go_link(1'b1);
    go_link(1'b0);
    repeat (2) pulse(1'b1);
    go_link(1'b1);
    expect_v(K_INV, 0, "R8 rearm");
    // R4 mixed polarity
    go_link(1'b0);
    pulse(1'b1); pulse(1'b1); pulse(1'b0); pulse(1'b1); pulse(1'b1);
    go_link(1'b1);
    expect_v(K_INV, 0, "R4 mixed");
    // R3 toward reversed then R12 kept through fail, then back to normal
    go_link(1'b0);
    repeat (5) pulse(1'b1);
    go_link(1'b1);
    expect_v(K_INV, 1, "R3 rev");
    go_link(1'b0);
    step(3);
    expect_v(K_INV, 1, "R12");
    repeat (5) pulse(1'b0);
    go_link(1'b1);
    expect_v(K_INV, 0, "R3 norm");
    expect_v(K_DOUT, 4'b1010, "R10");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule